// File: doc/BRIEF.md
# Byte Program Retry Sequencer

This block sits on the host side of a byte-wide non-volatile store whose cells can only move from one to zero. It writes a run of bytes that starts at a given address. For each byte it pulls one value from a source port and enters program mode with a set-up command. It then writes the address and data, which starts the program pulse, and waits for the pulse to finish. Next it issues a verify command, waits for the verify to settle, and reads the byte back. If the byte read back matches, the block moves on to the next address. If it does not match, the block runs a fresh attempt that begins again with the set-up command. After a fixed number of failed attempts on one byte, the block aborts the run and reports the address that failed.

While the run is in progress the block holds the programming-voltage enable high. At the end of every run, whether it succeeded or failed, the block writes the read command, drops the voltage enable and pulses `done`. Source bytes equal to FFh are accepted from the source port but never programmed, because no cell in them has to change. The pulse length and the verify wait are counted in clock cycles and set by parameters. Bus timing at the pins belongs to a separate layer.

Top module: `bps_top`

## Requirements
- R1: A `start` pulse sampled in idle with a nonzero `length` raises `vpp_en` and `busy`. Byte k then goes to address `start_addr`+k. Each attempt on a byte opens with a write of the set-up code 40h, followed in the very next cycle by a write of the source byte to that address.
- R2: The verify code C0h is written exactly `PULSE_CYC`+1 cycles after the data write. The read strobe `dev_re` is asserted exactly `VERIFY_CYC`+1 cycles after the verify write, and `dev_rdata` is sampled in that same cycle.
- R3: When the byte read back equals the source byte, the block fetches the next source byte and uses the next address. It makes no further attempt on the byte that verified.
- R4: When the byte read back differs, a new attempt starts with a 40h write in the cycle right after the read strobe, at the same address.
- R5: A source byte equal to FFh causes no device write at its address. The address still advances past it.
- R6: When `MAX_PULSES` verifies of one byte all miss, `err` rises and `err_addr` holds that byte's address. No further source byte is requested. `err` then stays high until the next `start`.
- R7: The attempt count starts from zero for every byte. A byte may therefore use up to `MAX_PULSES` attempts whatever the earlier bytes used.
- R8: Every run ends with a write of the read code 00h. In the following cycle `done` is high for exactly one cycle while `vpp_en` and `busy` are low.
- R9: A `start` with `length` zero requests no source byte and writes only the 00h read code before `done`.
- R10: After reset, `vpp_en`, `busy`, `done`, `err`, `src_req`, `dev_we` and `dev_re` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only in idle |
| start_addr | input | AW | Address of the first byte |
| length | input | LW | Number of bytes in the run |
| src_req | output | 1 | Block is ready to take a source byte |
| src_valid | input | 1 | Source byte is present; a byte transfers when both this and `src_req` are high |
| src_data | input | 8 | Source byte |
| dev_we | output | 1 | One-cycle device write strobe |
| dev_re | output | 1 | One-cycle device read strobe |
| dev_addr | output | AW | Device address |
| dev_wdata | output | 8 | Command code or program data |
| dev_rdata | input | 8 | Device read data, valid while `dev_re` is high |
| vpp_en | output | 1 | Programming-voltage enable |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 1 | Last run aborted on the attempt limit |
| err_addr | output | AW | Address that failed to verify |

## Verification
Every device strobe and `done` is decoded from the state register. Each of them therefore changes exactly one clock edge after the condition that causes it: the data write follows the set-up write by one cycle, and a retry set-up follows the read strobe by one cycle. The verify write and the read strobe arrive after the `PULSE_CYC`+1 and `VERIFY_CYC`+1 gaps. The bench time-stamps every strobe on the falling edge, away from the edge where the design updates. It compares each gap with those exact counts and reads the run results only in the falling-edge slot where `done` is seen. A byte-level model of the store clears bits only after a set number of program pulses per address, so retries, the attempt limit and skipped bytes all show up as pulse counts and final contents that can be checked.

// File: rtl/bps_pkg.sv
package bps_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CODE_SETUP  = 8'h40;
    localparam logic [BYTE_W-1:0] CODE_VERIFY = 8'hC0;
    localparam logic [BYTE_W-1:0] CODE_READ   = 8'h00;
    localparam logic [BYTE_W-1:0] BLANK_BYTE  = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FETCH,
        ST_SETUP,
        ST_PROG,
        ST_PWAIT,
        ST_VCMD,
        ST_VWAIT,
        ST_READ,
        ST_NEXT,
        ST_CLOSE,
        ST_END
    } seq_state_e;

endpackage

// File: rtl/bps_wait_timer.sv
module bps_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/bps_pulse_budget.sv
module bps_pulse_budget #(
    parameter int MAX_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int BW = $clog2(MAX_PULSES + 1);
    localparam logic [BW-1:0] LAST_VAL = BW'(MAX_PULSES - 1);

    logic [BW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)     cnt_d = '0;
        else if (bump) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // high while the attempt now under way is the final one allowed
    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/bps_top.sv
module bps_top
    import bps_pkg::*;
#(
    parameter int AW         = 18,
    parameter int LW         = 18,
    parameter int PULSE_CYC  = 2000,
    parameter int VERIFY_CYC = 1200,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [LW-1:0]     length,
    output logic              src_req,
    input  logic              src_valid,
    input  logic [BYTE_W-1:0] src_data,
    output logic              dev_we,
    output logic              dev_re,
    output logic [AW-1:0]     dev_addr,
    output logic [BYTE_W-1:0] dev_wdata,
    input  logic [BYTE_W-1:0] dev_rdata,
    output logic              vpp_en,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [AW-1:0]     err_addr
);
    localparam int LONGEST = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] PULSE_LOAD  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] VERIFY_LOAD = TW'(VERIFY_CYC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [AW-1:0]     addr;
        logic [LW-1:0]     left;
        logic [BYTE_W-1:0] data;
        logic              err;
        logic [AW-1:0]     err_addr;
    } seq_regs_t;

    seq_regs_t q, d;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          bud_clear;
    logic          bud_bump;
    logic          bud_last;

    bps_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    bps_pulse_budget #(.MAX_PULSES(MAX_PULSES)) u_budget (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (bud_clear),
        .bump  (bud_bump),
        .last  (bud_last)
    );

    always_comb begin
        d         = q;
        src_req   = 1'b0;
        dev_we    = 1'b0;
        dev_re    = 1'b0;
        dev_wdata = CODE_READ;
        tmr_load  = 1'b0;
        tmr_val   = PULSE_LOAD;
        bud_clear = 1'b0;
        bud_bump  = 1'b0;
        done      = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.addr = start_addr;
                    d.left = length;
                    d.err  = 1'b0;
                    d.st   = (length == '0) ? ST_CLOSE : ST_FETCH;
                end
            end
            ST_FETCH: begin
                src_req = 1'b1;
                if (src_valid) begin
                    d.data    = src_data;
                    bud_clear = 1'b1;
                    d.st      = (src_data == BLANK_BYTE) ? ST_NEXT : ST_SETUP;
                end
            end
            ST_SETUP: begin
                dev_we    = 1'b1;
                dev_wdata = CODE_SETUP;
                d.st      = ST_PROG;
            end
            ST_PROG: begin
                dev_we    = 1'b1;
                dev_wdata = q.data;
                tmr_load  = 1'b1;
                tmr_val   = PULSE_LOAD;
                d.st      = ST_PWAIT;
            end
            ST_PWAIT: begin
                if (tmr_zero) d.st = ST_VCMD;
            end
            ST_VCMD: begin
                dev_we    = 1'b1;
                dev_wdata = CODE_VERIFY;
                tmr_load  = 1'b1;
                tmr_val   = VERIFY_LOAD;
                d.st      = ST_VWAIT;
            end
            ST_VWAIT: begin
                if (tmr_zero) d.st = ST_READ;
            end
            ST_READ: begin
                dev_re   = 1'b1;
                bud_bump = 1'b1;
                if (dev_rdata == q.data) begin
                    d.st = ST_NEXT;
                end else if (bud_last) begin
                    d.err      = 1'b1;
                    d.err_addr = q.addr;
                    d.st       = ST_CLOSE;
                end else begin
                    d.st = ST_SETUP;
                end
            end
            ST_NEXT: begin
                d.addr = q.addr + 1'b1;
                d.left = q.left - 1'b1;
                d.st   = (q.left == LW'(1)) ? ST_CLOSE : ST_FETCH;
            end
            ST_CLOSE: begin
                dev_we    = 1'b1;
                dev_wdata = CODE_READ;
                d.st      = ST_END;
            end
            ST_END: begin
                done = 1'b1;
                d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st       <= ST_IDLE;
            q.addr     <= '0;
            q.left     <= '0;
            q.data     <= '0;
            q.err      <= 1'b0;
            q.err_addr <= '0;
        end else begin
            q <= d;
        end
    end

    assign dev_addr = q.addr;
    assign vpp_en   = (q.st != ST_IDLE) && (q.st != ST_END);
    assign busy     = vpp_en;
    assign err      = q.err;
    assign err_addr = q.err_addr;
endmodule

// File: rtl/bps_checks.sv
module bps_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       src_req,
    input logic       dev_we,
    input logic       dev_re,
    input logic [7:0] dev_wdata,
    input logic       vpp_en,
    input logic       busy,
    input logic       done,
    input logic       err
);
    // R1: a set-up write opening an attempt is followed at once by the data write
    a_r1_setup_then_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we && dev_wdata == 8'h40 && !$past(dev_we)) |=> dev_we);

    // R2: write and read strobes never coincide
    a_r2_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_we && dev_re));

    // R10: no device or source activity without the voltage enable
    a_r10_activity_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_we || dev_re || src_req) |-> vpp_en);

    // R8: done comes with the voltage dropped and lasts one cycle
    a_r8_done_vpp_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!vpp_en && !busy));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: an error flag holds until a new start
    a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);
endmodule

bind bps_top bps_checks u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_req   (src_req),
    .dev_we    (dev_we),
    .dev_re    (dev_re),
    .dev_wdata (dev_wdata),
    .vpp_en    (vpp_en),
    .busy      (busy),
    .done      (done),
    .err       (err)
);

// File: tb/bps_top_test.sv
`timescale 1ns/1ps
module bps_top_test;
    localparam int AW   = 8;
    localparam int LW   = 8;
    localparam int P    = 8;
    localparam int V    = 5;
    localparam int MAXP = 25;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] length = '0;
    logic          src_req, src_valid;
    logic [7:0]    src_data;
    logic          dev_we, dev_re;
    logic [AW-1:0] dev_addr;
    logic [7:0]    dev_wdata, dev_rdata;
    logic          vpp_en, busy, done, err;
    logic [AW-1:0] err_addr;

    always #2.5 clk = ~clk;

    bps_top #(.AW(AW), .LW(LW), .PULSE_CYC(P), .VERIFY_CYC(V), .MAX_PULSES(MAXP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .length(length),
        .src_req(src_req), .src_valid(src_valid), .src_data(src_data),
        .dev_we(dev_we), .dev_re(dev_re), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata), .vpp_en(vpp_en), .busy(busy), .done(done), .err(err),
        .err_addr(err_addr)
    );

    // store model and source feeder
    logic [7:0] mem [256];
    int         hard [256];
    int         pulses [256];
    int         setups [256];
    logic [7:0] src_mem [32];
    int         idx;
    bit         pend;
    int         cyc, t_data, t_vcmd, t_read, tim_bad;
    logic [AW-1:0] last_raddr;
    bit         expect_data;
    logic [7:0] last_cmd;
    int         n_checks, n_fails;

    assign src_valid = 1'b1;
    assign src_data  = src_mem[idx[4:0]];
    assign dev_rdata = mem[dev_addr];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pend) begin idx = idx + 1; pend = 0; end
        if (src_req && src_valid) pend = 1;
        if (dev_we) begin
            if (expect_data) begin
                expect_data = 0;
                pulses[dev_addr] = pulses[dev_addr] + 1;
                t_data = cyc;
                if (pulses[dev_addr] >= hard[dev_addr]) mem[dev_addr] = mem[dev_addr] & dev_wdata;
            end else begin
                last_cmd = dev_wdata;
                if (dev_wdata == 8'h40) begin
                    expect_data = 1;
                    setups[dev_addr] = setups[dev_addr] + 1;
                    if (t_read >= 0 && last_raddr == dev_addr && cyc - t_read != 1) tim_bad++;
                end else if (dev_wdata == 8'hC0) begin
                    if (cyc - t_data != P + 1) tim_bad++;
                    t_vcmd = cyc;
                end
            end
        end
        if (dev_re) begin
            if (cyc - t_vcmd != V + 1) tim_bad++;
            t_read = cyc;
            last_raddr = dev_addr;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic prep();
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'hFF; hard[i] = 1; pulses[i] = 0; setups[i] = 0;
        end
        idx = 0; pend = 0; tim_bad = 0; t_read = -1; expect_data = 0; last_cmd = 8'h55;
    endtask

    task automatic run(input int a, input int n);
        int w;
        @(negedge clk);
        start_addr = AW'(a); length = LW'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(done == 1'b1, "R8 done reached", done, 1);
        chk(vpp_en == 1'b0 && busy == 1'b0, "R8 vpp and busy low at done", {vpp_en, busy}, 0);
        chk(last_cmd == 8'h00, "R8 closing read code", last_cmd, 8'h00);
    endtask

    task automatic t_reset();
        chk({vpp_en, busy, done, err, src_req, dev_we, dev_re} == '0, "R10 reset outputs",
            {vpp_en, busy, done, err, src_req, dev_we, dev_re}, 0);
    endtask

    task automatic t_basic();
        logic [7:0] pat [4] = '{8'h3C, 8'hA5, 8'h00, 8'h7E};
        prep();
        for (int i = 0; i < 4; i++) src_mem[i] = pat[i];
        run(10, 4);
        for (int i = 0; i < 4; i++) begin
            chk(mem[10+i] == pat[i], "R1 R3 byte stored", mem[10+i], pat[i]);
            chk(pulses[10+i] == 1, "R3 single attempt", pulses[10+i], 1);
        end
        chk(idx == 4, "R3 bytes fetched", idx, 4);
        chk(err == 1'b0, "R6 no error", err, 0);
        chk(tim_bad == 0, "R2 pulse and verify gaps", tim_bad, 0);
    endtask

    task automatic t_retry();
        prep();
        src_mem[0] = 8'h12; src_mem[1] = 8'h34;
        hard[40] = 3;
        run(40, 2);
        chk(pulses[40] == 3, "R4 pulses on hard byte", pulses[40], 3);
        chk(setups[40] == 3, "R4 set-up per attempt", setups[40], 3);
        chk(mem[40] == 8'h12 && mem[41] == 8'h34, "R4 contents", {mem[40], mem[41]}, 16'h1234);
        chk(tim_bad == 0, "R4 R2 retry timing", tim_bad, 0);
    endtask

    task automatic t_skip();
        prep();
        src_mem[0] = 8'hFF; src_mem[1] = 8'h0F; src_mem[2] = 8'hFF;
        run(60, 3);
        chk(setups[60] + pulses[60] + setups[62] + pulses[62] == 0, "R5 blank bytes untouched",
            setups[60] + setups[62], 0);
        chk(pulses[61] == 1 && mem[61] == 8'h0F, "R5 middle byte programmed", mem[61], 8'h0F);
        chk(idx == 3, "R5 all bytes fetched", idx, 3);
    endtask

    task automatic t_budget_reset();
        prep();
        src_mem[0] = 8'h01; src_mem[1] = 8'h02;
        hard[80] = 3; hard[81] = 24;
        run(80, 2);
        chk(err == 1'b0, "R7 no error with fresh budget", err, 0);
        chk(pulses[81] == 24 && mem[81] == 8'h02, "R7 second byte", pulses[81], 24);
    endtask

    task automatic t_fail();
        prep();
        src_mem[0] = 8'hAA; src_mem[1] = 8'hBB; src_mem[2] = 8'hCC;
        hard[100] = 1000;
        run(99, 3);
        chk(err == 1'b1, "R6 error raised", err, 1);
        chk(err_addr == AW'(100), "R6 failing address", err_addr, 100);
        chk(pulses[100] == MAXP, "R6 attempt limit", pulses[100], MAXP);
        chk(idx == 2, "R6 no fetch after abort", idx, 2);
        chk(mem[101] == 8'hFF && setups[101] == 0, "R6 later byte untouched", mem[101], 8'hFF);
        repeat (3) @(negedge clk);
        chk(err == 1'b1, "R6 error held", err, 1);
    endtask

    task automatic t_zero();
        prep();
        run(5, 0);
        chk(idx == 0, "R9 no source request", idx, 0);
        chk(setups[5] == 0 && pulses[5] == 0, "R9 no program writes", setups[5], 0);
        chk(err == 1'b0, "R9 R6 error cleared by start", err, 0);
    endtask

    initial begin
        cyc = 0; n_checks = 0; n_fails = 0;
        for (int i = 0; i < 32; i++) src_mem[i] = 8'hFF;
        prep();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic();
        t_retry();
        t_skip();
        t_budget_reset();
        t_fail();
        t_zero();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=%0d expected=below 150000", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule